// File: doc/BRIEF.md
# Block Move Step Sequencer

This block carries out one step of an 8-bit processor's block-move instruction family. A start pulse arrives with a 2-bit variant code and the current copy-count, destination-pointer, source-pointer, accumulator and flag values. The block then reads one byte from the source pointer and writes it to the destination pointer. It uses a simple memory bus whose strobes are held until the memory answers with ready.

After the write, the block pads the step with wait cycles. It then returns the updated count, pointers and flag byte with a one-cycle done pulse. For the repeating variants, when the count has not yet reached zero, the block also raises a request to move the program counter back by two. That makes the enclosing core fetch the same instruction again. The block adds five extra wait cycles to that step, so the whole copy runs as a chain of identical steps.

The block models the documented flags and the two undocumented copy bits exactly. This lets it slot into a cycle-accurate core.

Top module: `blkmove_seq`

## Requirements
- R1: The variant code decodes as follows. Bit 0 set means decrement and bit 0 clear means increment. Bit 1 set means repeating and bit 1 clear means single. Codes 0, 1, 2 and 3 therefore correspond to the instruction opcodes 0xA0, 0xA8, 0xB0 and 0xB8.
- R2: A step first reads one byte at the address in `hl_in`, then writes that same byte at the address in `de_in`. The read and write strobes are never high together. Each strobe, together with its address, stays steady until `mem_rdy` is seen high.
- R3: Every step lowers the count by one, modulo 65536, so a count of 0 becomes 0xFFFF. Both pointers move by one in the direction from R1, also modulo 65536.
- R4: In the returned flags, bit 1 (subtract) and bit 4 (half carry) are always zero. Bits 7, 6 and 0 are copied from `f_in`.
- R5: Flag bit 2 is 1 when the decremented count is nonzero and 0 when it is zero.
- R6: Let S be the 8-bit sum of `a_in` and the moved byte. Flag bit 3 equals bit 3 of S, and flag bit 5 equals bit 1 of S.
- R7: `done` rises 2 clock cycles after the edge on which the write is accepted. For a repeating step whose decremented count is nonzero, it rises 7 cycles after that edge instead.
- R8: `pc_rewind` is high together with `done` only for a repeating variant whose decremented count is nonzero. Otherwise it stays low.
- R9: `done` lasts exactly one cycle. A start pulse arriving while `busy` is high is ignored: it gives no extra done pulse and does not alter the step in progress.
- R10: During and after reset, `busy`, `done`, `pc_rewind`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step, sampled while idle |
| variant | input | 2 | Bit 0: decrement; bit 1: repeating |
| bc_in | input | 16 | Copy count before the step |
| de_in | input | 16 | Destination pointer before the step |
| hl_in | input | 16 | Source pointer before the step |
| a_in | input | 8 | Accumulator value |
| f_in | input | 8 | Flag byte before the step |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| mem_rdy | input | 1 | Memory accepts the current strobe |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_rewind | output | 1 | Request to move the program counter back by 2 |
| bc_out | output | 16 | Updated count |
| de_out | output | 16 | Updated destination pointer |
| hl_out | output | 16 | Updated source pointer |
| f_out | output | 8 | Updated flag byte |

## Verification
The four variants are run against a memory model with zero, one and two wait states. This separates pad-length errors from bus-handshake errors in the measured start-to-done delay. Boundary counts are tried as well: a count of 1, which ends a repeat, and a count of 0, which wraps to 0xFFFF and keeps repeating. Pointers at 0x0000 and 0xFFFF expose wrap and direction faults. Several accumulator and byte pairs move the two copied sum bits independently, and a full repeating copy loop shows that the rewind chain moves every byte. A start pulse injected mid-step shows whether the block latches new operands while busy.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_PAD} seq_state_t;

  // flag byte bit positions
  localparam int FB_CARRY  = 0;
  localparam int FB_SUB    = 1;
  localparam int FB_PARITY = 2;
  localparam int FB_COPY3  = 3;
  localparam int FB_HALF   = 4;
  localparam int FB_COPY5  = 5;
  localparam int FB_ZERO   = 6;
  localparam int FB_SIGN   = 7;

  typedef struct packed {
    logic rep;
    logic dec;
  } variant_t;

  function automatic variant_t decode_variant(input logic [1:0] code);
    variant_t v;
    v.dec = code[0];
    v.rep = code[1];
    return v;
  endfunction
endpackage

// File: rtl/blkmove_update.sv
module blkmove_update
  import blkmove_pkg::*;
#(
  parameter int RW = 16,
  parameter int DW = 8
) (
  input  logic          dec,
  input  logic          rep,
  input  logic [RW-1:0] bc_i,
  input  logic [RW-1:0] de_i,
  input  logic [RW-1:0] hl_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] flg_i,
  input  logic [DW-1:0] byte_i,
  output logic [RW-1:0] bc_o,
  output logic [RW-1:0] de_o,
  output logic [RW-1:0] hl_o,
  output logic [DW-1:0] flg_o,
  output logic          again_o
);
  logic [DW-1:0] sum;

  always_comb begin
    sum  = acc_i + byte_i;
    bc_o = bc_i - RW'(1);
    de_o = dec ? (de_i - RW'(1)) : (de_i + RW'(1));
    hl_o = dec ? (hl_i - RW'(1)) : (hl_i + RW'(1));
    flg_o            = flg_i;
    flg_o[FB_SUB]    = 1'b0;
    flg_o[FB_HALF]   = 1'b0;
    flg_o[FB_PARITY] = |bc_o;
    flg_o[FB_COPY3]  = sum[3];
    flg_o[FB_COPY5]  = sum[1];
    again_o          = rep & (|bc_o);
  end
endmodule

// File: rtl/blkmove_padcnt.sv
module blkmove_padcnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
#(
  parameter int RW         = 16,
  parameter int DW         = 8,
  parameter int PAD_BASE   = 2,
  parameter int PAD_REPEAT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    variant,
  input  logic [RW-1:0] bc_in,
  input  logic [RW-1:0] de_in,
  input  logic [RW-1:0] hl_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] f_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [RW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done,
  output logic          pc_rewind,
  output logic [RW-1:0] bc_out,
  output logic [RW-1:0] de_out,
  output logic [RW-1:0] hl_out,
  output logic [DW-1:0] f_out
);
  localparam int PAD_MAX = PAD_BASE + PAD_REPEAT;
  localparam int CW      = $clog2(PAD_MAX + 1);

  seq_state_t    state;
  variant_t      var_r;
  logic [RW-1:0] bc_r, de_r, hl_r;
  logic [DW-1:0] acc_r, flg_r, byte_r;
  logic          rewind_r;

  logic [RW-1:0] bc_n, de_n, hl_n;
  logic [DW-1:0] flg_n;
  logic          again;
  logic          wr_accept;
  logic          pad_zero;
  logic [CW-1:0] pad_val;

  blkmove_update #(.RW(RW), .DW(DW)) u_update (
    .dec(var_r.dec), .rep(var_r.rep),
    .bc_i(bc_r), .de_i(de_r), .hl_i(hl_r),
    .acc_i(acc_r), .flg_i(flg_r), .byte_i(byte_r),
    .bc_o(bc_n), .de_o(de_n), .hl_o(hl_n),
    .flg_o(flg_n), .again_o(again)
  );

  assign wr_accept = (state == ST_WRITE) && mem_rdy;
  assign pad_val   = again ? CW'(PAD_MAX - 1) : CW'(PAD_BASE - 1);

  blkmove_padcnt #(.CW(CW)) u_pad (
    .clk(clk), .rst(rst), .load(wr_accept),
    .load_val(pad_val), .zero(pad_zero)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      var_r     <= '0;
      bc_r      <= '0;
      de_r      <= '0;
      hl_r      <= '0;
      acc_r     <= '0;
      flg_r     <= '0;
      byte_r    <= '0;
      rewind_r  <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      pc_rewind <= 1'b0;
      bc_out    <= '0;
      de_out    <= '0;
      hl_out    <= '0;
      f_out     <= '0;
    end else begin
      done      <= 1'b0;
      pc_rewind <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          var_r    <= decode_variant(variant);
          bc_r     <= bc_in;
          de_r     <= de_in;
          hl_r     <= hl_in;
          acc_r    <= a_in;
          flg_r    <= f_in;
          mem_rd   <= 1'b1;
          mem_addr <= hl_in;
          state    <= ST_READ;
        end
        ST_READ: if (mem_rdy) begin
          byte_r    <= mem_rdata;
          mem_rd    <= 1'b0;
          mem_wr    <= 1'b1;
          mem_addr  <= de_r;
          mem_wdata <= mem_rdata;
          state     <= ST_WRITE;
        end
        ST_WRITE: if (mem_rdy) begin
          mem_wr   <= 1'b0;
          bc_out   <= bc_n;
          de_out   <= de_n;
          hl_out   <= hl_n;
          f_out    <= flg_n;
          rewind_r <= again;
          state    <= ST_PAD;
        end
        ST_PAD: if (pad_zero) begin
          done      <= 1'b1;
          pc_rewind <= rewind_r;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkmove_seq_chk.sv
module blkmove_seq_chk #(
  parameter int RW         = 16,
  parameter int DW         = 8,
  parameter int PAD_BASE   = 2,
  parameter int PAD_REPEAT = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          pc_rewind,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_rdy,
  input logic [RW-1:0] mem_addr,
  input logic [RW-1:0] bc_out,
  input logic [DW-1:0] f_out
);
  logic [7:0] since_wr;

  always_ff @(posedge clk) begin
    if (rst)                               since_wr <= '0;
    else if (mem_wr && mem_rdy)            since_wr <= 8'd1;
    else if (since_wr != 0 && since_wr != 8'hFF) since_wr <= since_wr + 8'd1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd && !mem_rdy |=> mem_rd && $stable(mem_addr));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr && !mem_rdy |=> mem_wr && $stable(mem_addr));
  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_rd && !mem_wr);
  // R8
  rewind_with_done_chk: assert property (@(posedge clk) disable iff (rst) pc_rewind |-> done);
  // R8
  rewind_count_chk: assert property (@(posedge clk) disable iff (rst)
    done && pc_rewind |-> bc_out != '0);
  // R5
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> f_out[2] == (bc_out != '0));
  // R4
  sub_half_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !f_out[1] && !f_out[4]);
  // R7
  pad_len_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> since_wr == (pc_rewind ? 8'(PAD_BASE + PAD_REPEAT + 1) : 8'(PAD_BASE + 1)));
endmodule

bind blkmove_seq blkmove_seq_chk #(
  .RW(RW), .DW(DW), .PAD_BASE(PAD_BASE), .PAD_REPEAT(PAD_REPEAT)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pc_rewind(pc_rewind),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
  .bc_out(bc_out), .f_out(f_out)
);

// File: tb/blkmove_seq_bench.sv
`timescale 1ns/1ps
module blkmove_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  variant = '0;
  logic [15:0] bc_in = '0, de_in = '0, hl_in = '0;
  logic [7:0]  a_in = '0, f_in = '0;
  logic        mem_rd, mem_wr, mem_rdy, busy, done, pc_rewind;
  logic [15:0] mem_addr, bc_out, de_out, hl_out;
  logic [7:0]  mem_wdata, mem_rdata, f_out;

  always #2.5 clk = ~clk;

  blkmove_seq u_blkmove_seq (
    .clk(clk), .rst(rst), .start(start), .variant(variant),
    .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .a_in(a_in), .f_in(f_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done),
    .pc_rewind(pc_rewind), .bc_out(bc_out), .de_out(de_out), .hl_out(hl_out),
    .f_out(f_out)
  );

  // memory model
  logic [7:0]  mem   [0:65535];
  bit          wrote [0:65535];
  int          lat = 0;
  int          wcnt = 0;
  int unsigned ncnt = 0;
  logic [15:0] last_raddr = '0, last_waddr = '0;
  logic [7:0]  last_wdata = '0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_model(input logic [15:0] a);
    return wrote[a] ? mem[a] : pat(a);
  endfunction

  assign mem_rdy   = (mem_rd | mem_wr) && (wcnt == lat);
  assign mem_rdata = rd_model(mem_addr);

  always @(posedge clk) begin
    ncnt <= ncnt + 1;
    if ((mem_rd | mem_wr) && !mem_rdy) wcnt <= wcnt + 1;
    else                               wcnt <= 0;
    if (mem_rd && mem_rdy) last_raddr <= mem_addr;
    if (mem_wr && mem_rdy) begin
      mem[mem_addr]   <= mem_wdata;
      wrote[mem_addr] <= 1'b1;
      last_waddr      <= mem_addr;
      last_wdata      <= mem_wdata;
    end
  end

  // scoreboard
  typedef struct {
    logic [15:0] bc, de, hl, raddr, waddr;
    logic [7:0]  f, wdata;
    logic        rew;
    int unsigned dly, t0;
  } exp_t;
  exp_t q[$];
  exp_t e;
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk("R9", "unexpected done pulse", 1, 0);
      end else begin
        e = q.pop_front();
        chk("R3",    "count",            bc_out, e.bc);
        chk("R1/R3", "destination",      de_out, e.de);
        chk("R1/R3", "source",           hl_out, e.hl);
        chk("R4",    "sign/zero/carry",  {f_out[7], f_out[6], f_out[0]}, {e.f[7], e.f[6], e.f[0]});
        chk("R4",    "sub/half",         {f_out[1], f_out[4]}, 2'b00);
        chk("R5",    "parity bit",       f_out[2], e.f[2]);
        chk("R6",    "copy bits 3/5",    {f_out[5], f_out[3]}, {e.f[5], e.f[3]});
        chk("R8",    "rewind",           pc_rewind, e.rew);
        chk("R7",    "start-to-done",    ncnt - e.t0, e.dly);
        chk("R2",    "read address",     last_raddr, e.raddr);
        chk("R2",    "write address",    last_waddr, e.waddr);
        chk("R2",    "write data",       last_wdata, e.wdata);
      end
    end
  end

  task automatic launch(input logic [1:0] v, input logic [15:0] bc, de, hl,
                        input logic [7:0] a, f);
    exp_t x;
    logic [7:0] b, s;
    int pad;
    while (busy) @(negedge clk);
    b = rd_model(hl);
    s = a + b;
    x.bc = bc - 16'd1;
    x.de = v[0] ? de - 16'd1 : de + 16'd1;
    x.hl = v[0] ? hl - 16'd1 : hl + 16'd1;
    x.f = f;
    x.f[1] = 1'b0; x.f[4] = 1'b0;
    x.f[2] = (x.bc != 0);
    x.f[3] = s[3]; x.f[5] = s[1];
    x.rew = v[1] && (x.bc != 0);
    pad = x.rew ? 7 : 2;
    x.dly = 2 * (lat + 1) + pad + 1;
    x.raddr = hl; x.waddr = de; x.wdata = b;
    @(negedge clk);
    variant = v; bc_in = bc; de_in = de; hl_in = hl; a_in = a; f_in = f;
    start = 1'b1;
    x.t0 = ncnt;
    q.push_back(x);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic step(input logic [1:0] v, input logic [15:0] bc, de, hl,
                      input logic [7:0] a, f);
    launch(v, bc, de, hl, a, f);
    wait_done();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] cbc, cde, chl;
    int iters;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", "busy",   busy, 0);
    chk("R10", "done",   done, 0);
    chk("R10", "rewind", pc_rewind, 0);
    chk("R10", "strobes", {mem_rd, mem_wr}, 2'b00);
    rst = 1'b0;
    @(negedge clk);

    // R1 single increment, zero wait states
    lat = 0;
    step(2'd0, 16'd3, 16'h2000, 16'h1000, 8'h10, 8'hFF);
    // R1 single decrement, count 1 -> 0 (R5)
    lat = 1;
    step(2'd1, 16'd1, 16'h2100, 16'h1100, 8'h03, 8'h00);
    // R8 repeating increment, count stays nonzero
    lat = 2;
    step(2'd2, 16'd5, 16'h2200, 16'h1200, 8'h7F, 8'hC1);
    // R8 repeating increment ending (count 1)
    lat = 0;
    step(2'd2, 16'd1, 16'h2300, 16'h1300, 8'h22, 8'h41);
    // R3 repeating decrement, count 0 wraps, source wraps at 0
    lat = 1;
    step(2'd3, 16'd0, 16'h2400, 16'h0000, 8'hA5, 8'h80);
    // R3 single increment with both pointers at top of range
    lat = 0;
    step(2'd0, 16'd9, 16'hFFFF, 16'hFFFF, 8'h00, 8'h01);
    // R6 several accumulator values over the same source
    for (int i = 0; i < 4; i++) begin
      lat = i % 3;
      step(2'd1, 16'd7, 16'h2500 + 16'(i), 16'h1500, 8'(i * 8'h55), 8'h00);
    end

    // R9: start while busy is ignored
    lat = 2;
    launch(2'd2, 16'd4, 16'h2600, 16'h1600, 8'h11, 8'h00);
    @(negedge clk); @(negedge clk);
    variant = 2'd1; bc_in = 16'd1; de_in = 16'h2700; hl_in = 16'h1700;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk("R9", "pending items after ignored start", q.size(), 0);
    chk("R9", "idle after step", busy, 0);

    // R8/R2: full repeating copy chain of four bytes
    lat = 1;
    cbc = 16'd4; cde = 16'h4000; chl = 16'h3000; iters = 0;
    do begin
      launch(2'd2, cbc, cde, chl, 8'h00, 8'h00);
      wait_done();
      iters++;
      cbc = bc_out; cde = de_out; chl = hl_out;
      @(negedge clk);
    end while (pc_rewind_seen(cbc) && iters < 10);
    chk("R8", "repeat iterations", iters, 4);
    for (int i = 0; i < 4; i++)
      chk("R2", "copied byte", rd_model(16'h4000 + 16'(i)), pat(16'h3000 + 16'(i)));

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // the chain continues while the block asked for a rewind; with R8 that is
  // exactly a nonzero count after the step
  function automatic bit pc_rewind_seen(input logic [15:0] c);
    return c != 0;
  endfunction
endmodule